// File: doc/BRIEF.md
# Redundant Bitstream Recovery Sequencer

This block decides what to do when an integrity check of a programmable target device reports a mismatch. The device can be loaded from any of three external stores that all hold the same configuration image. While nothing is wrong, the sequencer keeps asking for integrity checks. When a check fails, it picks a different healthy store, pulls the device's active-low program line for a set number of cycles, and waits a bounded time for the device to report that configuration is done. It then asks for one more check.

The result of that second check tells the two failure causes apart, even though neither the check nor the sequencer can say where a fault sits. If the device now passes, the image in the store used before was bad. That store is flagged faulty, it gets a one-cycle refresh request, and the new store becomes the active one. If the device still fails, or never reports done, the fault lies in the device itself, and the sequencer raises a bypass flag. It also raises bypass when no other healthy store is left. It then stops issuing requests until the flags are cleared.

Only after all of that target activity has ended does the sequencer send a one-cycle request for the controller to refresh itself. All flags are sticky: they stay set until reset or until the clear input is applied.

Top module: `cfg_recovery_seq`

## Requirements
- R1: After reset, `prog_n_o` is high, `check_req_o` is high, `store_sel_o` is 0, and `store_faulty_o`, `store_refresh_o`, `bypass_o` and `self_refresh_o` are all 0.
- R2: A passing check result while monitoring causes no action. A failing one makes the sequencer choose the next store in the rotation 0→1→2→0, starting after the active store and skipping stores flagged faulty. That store is shown on `store_sel_o` while `prog_n_o` is driven low. The active store itself is never chosen.
- R3: `prog_n_o` stays low for exactly `prog_len_i` consecutive cycles, with 0 treated as 1. `check_req_o` is low throughout that time.
- R4: After the program line is released, a `cfg_done_i` seen in any of the next `done_limit_i` cycles (0 treated as 1) is accepted. The next cycle then raises `check_req_o`, with the candidate store still on `store_sel_o`.
- R5: If that check passes, bit i of `store_faulty_o` is set for the previously active store i. `store_refresh_o` carries a one-cycle pulse on bit i only. From then on the candidate is the active store shown on `store_sel_o`.
- R6: If that check fails, or `cfg_done_i` is not seen within `done_limit_i` cycles, `bypass_o` is raised.
- R7: If every store other than the active one is flagged faulty, a failing check raises `bypass_o` without any pulse on `prog_n_o`.
- R8: Each recovery episode produces exactly one one-cycle `self_refresh_o` pulse. It comes after the store refresh pulse when there is one, and never while `prog_n_o` is low.
- R9: While `bypass_o` is set and no clear is applied, `check_req_o` stays low, `prog_n_o` stays high, and check results are ignored.
- R10: `store_faulty_o` and `bypass_o` hold their value until reset or `clear_i`. `clear_i` zeroes them, returns a bypassed sequencer to monitoring, and keeps the active store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear_i | input | 1 | Clears all sticky flags and leaves the bypass halt |
| prog_len_i | input | CNT_W | Cycles the program line is held low (0 acts as 1) |
| done_limit_i | input | CNT_W | Cycles allowed for configuration-done (0 acts as 1) |
| check_req_o | output | 1 | Requests an integrity check of the target |
| check_done_i | input | 1 | One-cycle strobe: a check result is valid |
| check_pass_i | input | 1 | Check result, 1 = signature matched |
| prog_n_o | output | 1 | Active-low program line of the target |
| cfg_done_i | input | 1 | Target reports configuration complete |
| store_sel_o | output | SEL_W | Index of the store feeding the target |
| store_refresh_o | output | NSTORE | One-hot, one-cycle refresh request per store |
| store_faulty_o | output | NSTORE | Sticky faulty flag per store |
| bypass_o | output | 1 | Sticky permanent-device-fault flag |
| self_refresh_o | output | 1 | One-cycle request to refresh the controller |

## Verification
The recovery path is swept over program lengths 0 to 4 and several done delays, so the active store rotates through every index. These runs separate an off-by-one in the program timer, a wrong rotation step, and a wrong index for the flagged or refreshed store. Done-timeout limits of 1 to 3 are each run once with no done and once with done arriving in the very last allowed cycle, which shows whether the window edge is placed correctly. Other runs cover a failing confirmation check, and two store-faulting passes followed by a third failure that exhausts the spares; these separate a device fault from a store fault and from running out of stores. Check results given during the bypass halt, and long idle stretches between clears, show whether the flags are really sticky and whether inputs leak through the halt.

// File: rtl/crs_pkg.sv
`timescale 1ns/1ps
package crs_pkg;

    typedef enum logic [2:0] {
        ST_MON,
        ST_PICK,
        ST_PROG,
        ST_WAIT,
        ST_VERIFY,
        ST_REFRESH,
        ST_SELFREF,
        ST_HALT
    } crs_state_t;

    // Per-state output drive, decoded from the state alone (Moore outputs).
    typedef struct packed {
        logic req_check;
        logic prog_low;
        logic refresh;
        logic self_ref;
        logic show_cand;
    } crs_drive_t;

    function automatic crs_drive_t drive_of(crs_state_t s);
        crs_drive_t d;
        d = '0;
        case (s)
            ST_MON:     d.req_check = 1'b1;
            ST_PROG:    begin d.prog_low = 1'b1; d.show_cand = 1'b1; end
            ST_WAIT:    d.show_cand = 1'b1;
            ST_VERIFY:  begin d.req_check = 1'b1; d.show_cand = 1'b1; end
            ST_REFRESH: d.refresh = 1'b1;
            ST_SELFREF: d.self_ref = 1'b1;
            default:    d = '0;
        endcase
        return d;
    endfunction

    // Index reached by moving 'step' places forward from 'base' in a ring of 'n'.
    function automatic int rot_index(int base, int step, int n);
        return (base + step) % n;
    endfunction

endpackage

// File: rtl/crs_store_pick.sv
`timescale 1ns/1ps
module crs_store_pick #(
    parameter int NSTORE = 3,
    parameter int SEL_W  = 2
) (
    input  logic [SEL_W-1:0]  active_i,
    input  logic [NSTORE-1:0] faulty_i,
    output logic              found_o,
    output logic [SEL_W-1:0]  pick_o
);
    localparam int NCAND = NSTORE - 1;

    logic [SEL_W-1:0] cand [NCAND];
    logic [NCAND-1:0] healthy;

    generate
        for (genvar g = 0; g < NCAND; g++) begin : g_cand
            assign cand[g]    = SEL_W'(crs_pkg::rot_index(int'(active_i), g + 1, NSTORE));
            assign healthy[g] = ~faulty_i[cand[g]];
        end
    endgenerate

    // Nearest healthy store in rotation order wins.
    always_comb begin
        found_o = 1'b0;
        pick_o  = active_i;
        for (int i = NCAND - 1; i >= 0; i--) begin
            if (healthy[i]) begin
                found_o = 1'b1;
                pick_o  = cand[i];
            end
        end
    end

endmodule

// File: rtl/crs_timer.sv
`timescale 1ns/1ps
module crs_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             step_i,
    output logic             last_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= (load_val_i == '0) ? CNT_W'(1) : load_val_i;
        end else if (step_i && cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign last_o = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/crs_flags.sv
`timescale 1ns/1ps
module crs_flags #(
    parameter int NSTORE = 3,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              mark_i,
    input  logic [SEL_W-1:0]  mark_idx_i,
    input  logic              bypass_set_i,
    output logic [NSTORE-1:0] faulty_o,
    output logic              bypass_o
);
    generate
        for (genvar g = 0; g < NSTORE; g++) begin : g_flag
            always_ff @(posedge clk) begin
                if (rst || clear_i) begin
                    faulty_o[g] <= 1'b0;
                end else if (mark_i && (mark_idx_i == SEL_W'(g))) begin
                    faulty_o[g] <= 1'b1;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            bypass_o <= 1'b0;
        end else if (bypass_set_i) begin
            bypass_o <= 1'b1;
        end
    end

endmodule

// File: rtl/cfg_recovery_seq.sv
`timescale 1ns/1ps
module cfg_recovery_seq
    import crs_pkg::*;
#(
    parameter int NSTORE = 3,
    parameter int CNT_W  = 16,
    localparam int SEL_W = (NSTORE > 1) ? $clog2(NSTORE) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic [CNT_W-1:0]  prog_len_i,
    input  logic [CNT_W-1:0]  done_limit_i,
    output logic              check_req_o,
    input  logic              check_done_i,
    input  logic              check_pass_i,
    output logic              prog_n_o,
    input  logic              cfg_done_i,
    output logic [SEL_W-1:0]  store_sel_o,
    output logic [NSTORE-1:0] store_refresh_o,
    output logic [NSTORE-1:0] store_faulty_o,
    output logic              bypass_o,
    output logic              self_refresh_o
);
    crs_state_t       state_q, state_d;
    crs_drive_t       drv;
    logic [SEL_W-1:0] active_q, cand_q, victim_q;
    logic             pick_found;
    logic [SEL_W-1:0] pick_idx;
    logic             tmr_load, tmr_step, tmr_last;
    logic [CNT_W-1:0] tmr_val;
    logic             mark, bypass_set;

    crs_store_pick #(.NSTORE(NSTORE), .SEL_W(SEL_W)) u_pick (
        .active_i (active_q),
        .faulty_i (store_faulty_o),
        .found_o  (pick_found),
        .pick_o   (pick_idx)
    );

    crs_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .step_i     (tmr_step),
        .last_o     (tmr_last)
    );

    crs_flags #(.NSTORE(NSTORE), .SEL_W(SEL_W)) u_flags (
        .clk          (clk),
        .rst          (rst),
        .clear_i      (clear_i),
        .mark_i       (mark),
        .mark_idx_i   (active_q),
        .bypass_set_i (bypass_set),
        .faulty_o     (store_faulty_o),
        .bypass_o     (bypass_o)
    );

    always_comb begin
        state_d    = state_q;
        tmr_load   = 1'b0;
        tmr_val    = prog_len_i;
        tmr_step   = 1'b0;
        mark       = 1'b0;
        bypass_set = 1'b0;
        case (state_q)
            ST_MON: begin
                if (check_done_i && !check_pass_i) state_d = ST_PICK;
            end
            ST_PICK: begin
                if (pick_found) begin
                    tmr_load = 1'b1;
                    tmr_val  = prog_len_i;
                    state_d  = ST_PROG;
                end else begin
                    bypass_set = 1'b1;
                    state_d    = ST_SELFREF;
                end
            end
            ST_PROG: begin
                tmr_step = 1'b1;
                if (tmr_last) begin
                    tmr_load = 1'b1;
                    tmr_val  = done_limit_i;
                    state_d  = ST_WAIT;
                end
            end
            ST_WAIT: begin
                tmr_step = 1'b1;
                if (cfg_done_i) begin
                    state_d = ST_VERIFY;
                end else if (tmr_last) begin
                    bypass_set = 1'b1;
                    state_d    = ST_SELFREF;
                end
            end
            ST_VERIFY: begin
                if (check_done_i) begin
                    if (check_pass_i) begin
                        mark    = 1'b1;
                        state_d = ST_REFRESH;
                    end else begin
                        bypass_set = 1'b1;
                        state_d    = ST_SELFREF;
                    end
                end
            end
            ST_REFRESH: state_d = ST_SELFREF;
            ST_SELFREF: state_d = bypass_o ? ST_HALT : ST_MON;
            ST_HALT:    if (clear_i) state_d = ST_MON;
            default:    state_d = ST_MON;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_MON;
            active_q <= '0;
            cand_q   <= '0;
            victim_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_PICK && pick_found) cand_q <= pick_idx;
            if (mark) begin
                victim_q <= active_q;
                active_q <= cand_q;
            end
        end
    end

    assign drv             = drive_of(state_q);
    assign check_req_o     = drv.req_check;
    assign prog_n_o        = ~drv.prog_low;
    assign self_refresh_o  = drv.self_ref;
    assign store_sel_o     = drv.show_cand ? cand_q : active_q;
    assign store_refresh_o = drv.refresh ? (NSTORE'(1) << victim_q) : '0;

endmodule

// File: rtl/crs_recovery_seq_chk.sv
`timescale 1ns/1ps
module crs_recovery_seq_chk #(
    parameter int NSTORE = 3,
    localparam int SEL_W = (NSTORE > 1) ? $clog2(NSTORE) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic              clear_i,
    input logic              check_req_o,
    input logic              prog_n_o,
    input logic [SEL_W-1:0]  store_sel_o,
    input logic [NSTORE-1:0] store_refresh_o,
    input logic [NSTORE-1:0] store_faulty_o,
    input logic              bypass_o,
    input logic              self_refresh_o
);
    // R3
    prog_no_check_chk: assert property (@(posedge clk) disable iff (rst)
        !prog_n_o |-> !check_req_o);

    // R5
    refresh_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(store_refresh_o));

    // R5
    refresh_flagged_chk: assert property (@(posedge clk) disable iff (rst)
        (store_refresh_o & ~store_faulty_o) == '0);

    // R8
    refresh_then_self_chk: assert property (@(posedge clk) disable iff (rst)
        (|store_refresh_o) |=> self_refresh_o);

    // R8
    self_not_in_prog_chk: assert property (@(posedge clk) disable iff (rst)
        self_refresh_o |-> prog_n_o);

    // R8
    self_single_chk: assert property (@(posedge clk) disable iff (rst)
        self_refresh_o |=> !self_refresh_o);

    // R9
    bypass_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        bypass_o |-> prog_n_o);

    // R10
    bypass_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (bypass_o && !clear_i) |=> bypass_o);

    // R10
    faulty_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !clear_i |=> ((store_faulty_o & $past(store_faulty_o)) == $past(store_faulty_o)));

    // R2
    sel_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'(store_sel_o) < NSTORE);

endmodule

bind cfg_recovery_seq crs_recovery_seq_chk #(.NSTORE(NSTORE)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .clear_i         (clear_i),
    .check_req_o     (check_req_o),
    .prog_n_o        (prog_n_o),
    .store_sel_o     (store_sel_o),
    .store_refresh_o (store_refresh_o),
    .store_faulty_o  (store_faulty_o),
    .bypass_o        (bypass_o),
    .self_refresh_o  (self_refresh_o)
);

// File: tb/cfg_recovery_seq_tb.sv
`timescale 1ns/1ps
module cfg_recovery_seq_tb;
    localparam int NS = 3;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          clear_i;
    logic [CW-1:0] prog_len_i;
    logic [CW-1:0] done_limit_i;
    logic          check_req_o;
    logic          check_done_i;
    logic          check_pass_i;
    logic          prog_n_o;
    logic          cfg_done_i;
    logic [1:0]    store_sel_o;
    logic [NS-1:0] store_refresh_o;
    logic [NS-1:0] store_faulty_o;
    logic          bypass_o;
    logic          self_refresh_o;

    always #2.5 clk = ~clk;

    cfg_recovery_seq #(.NSTORE(NS), .CNT_W(CW)) u_dut (
        .clk(clk), .rst(rst), .clear_i(clear_i),
        .prog_len_i(prog_len_i), .done_limit_i(done_limit_i),
        .check_req_o(check_req_o), .check_done_i(check_done_i),
        .check_pass_i(check_pass_i), .prog_n_o(prog_n_o),
        .cfg_done_i(cfg_done_i), .store_sel_o(store_sel_o),
        .store_refresh_o(store_refresh_o), .store_faulty_o(store_faulty_o),
        .bypass_o(bypass_o), .self_refresh_o(self_refresh_o)
    );

    int total = 0;
    int bad   = 0;
    int act_m = 0;
    logic [NS-1:0] flt_m = '0;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_clear();
        clear_i = 1'b1;
        @(negedge clk);
        clear_i = 1'b0;
        flt_m = '0;
        chk("R10 clear zeroes faulty flags", int'(store_faulty_o), 0);
        chk("R10 clear drops bypass", int'(bypass_o), 0);
        chk("R10 clear returns to monitoring", int'(check_req_o), 1);
        chk("R10 clear keeps active store", int'(store_sel_o), act_m);
    endtask

    // One recovery episode; done_at = 0 means configuration-done never arrives.
    task automatic recover(input int pl, input int lim, input int done_at, input bit vpass);
        int  cand;
        bit  found;
        int  width;
        int  w;
        found = 1'b0;
        cand  = 0;
        prog_len_i   = CW'(pl);
        done_limit_i = CW'(lim);
        for (int k = NS - 1; k >= 1; k--) begin
            if (!flt_m[(act_m + k) % NS]) begin
                found = 1'b1;
                cand  = (act_m + k) % NS;
            end
        end
        check_done_i = 1'b1;
        check_pass_i = 1'b0;
        @(negedge clk);
        check_done_i = 1'b0;
        chk("R2 program high while choosing", int'(prog_n_o), 1);
        @(negedge clk);
        if (!found) begin
            chk("R7 bypass when no spare store", int'(bypass_o), 1);
            chk("R7 no program pulse", int'(prog_n_o), 1);
            chk("R8 self refresh after bypass", int'(self_refresh_o), 1);
            @(negedge clk);
            chk("R9 halted without check request", int'(check_req_o), 0);
            return;
        end
        chk("R2 program low after failed check", int'(prog_n_o), 0);
        chk("R2 next healthy store selected", int'(store_sel_o), cand);
        chk("R3 no check request while programming", int'(check_req_o), 0);
        width = 0;
        while (prog_n_o == 1'b0 && width < 1000) begin
            width++;
            @(negedge clk);
        end
        chk("R3 program low width", width, (pl == 0) ? 1 : pl);
        if (done_at == 0) begin
            w = 0;
            while (bypass_o == 1'b0 && w < 1000) begin
                w++;
                @(negedge clk);
            end
            chk("R6 done timeout length", w, (lim == 0) ? 1 : lim);
            chk("R8 self refresh on timeout", int'(self_refresh_o), 1);
            @(negedge clk);
            chk("R9 no check request after timeout", int'(check_req_o), 0);
            return;
        end
        repeat (done_at - 1) @(negedge clk);
        cfg_done_i = 1'b1;
        @(negedge clk);
        cfg_done_i = 1'b0;
        chk("R4 check requested after done", int'(check_req_o), 1);
        chk("R4 candidate still selected", int'(store_sel_o), cand);
        check_done_i = 1'b1;
        check_pass_i = vpass;
        @(negedge clk);
        check_done_i = 1'b0;
        check_pass_i = 1'b0;
        if (vpass) begin
            chk("R5 refresh pulse on old store", int'(store_refresh_o), 1 << act_m);
            flt_m[act_m] = 1'b1;
            chk("R5 old store flagged faulty", int'(store_faulty_o), int'(flt_m));
            chk("R8 no self refresh before store refresh", int'(self_refresh_o), 0);
            chk("R6 no bypass on store fault", int'(bypass_o), 0);
            act_m = cand;
            @(negedge clk);
            chk("R8 self refresh follows store refresh", int'(self_refresh_o), 1);
            chk("R5 refresh pulse lasts one cycle", int'(store_refresh_o), 0);
            @(negedge clk);
            chk("R8 self refresh lasts one cycle", int'(self_refresh_o), 0);
            chk("R5 candidate becomes active", int'(store_sel_o), act_m);
            chk("R2 monitoring resumed", int'(check_req_o), 1);
        end else begin
            chk("R6 bypass on repeated failure", int'(bypass_o), 1);
            chk("R8 self refresh after bypass", int'(self_refresh_o), 1);
            chk("R6 store not flagged on device fault", int'(store_faulty_o), int'(flt_m));
            @(negedge clk);
            chk("R9 halted without check request", int'(check_req_o), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        clear_i = 1'b0;
        check_done_i = 1'b0;
        check_pass_i = 1'b0;
        cfg_done_i = 1'b0;
        prog_len_i = CW'(2);
        done_limit_i = CW'(3);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset program high", int'(prog_n_o), 1);
        chk("R1 reset check request", int'(check_req_o), 1);
        chk("R1 reset store select", int'(store_sel_o), 0);
        chk("R1 reset faulty flags", int'(store_faulty_o), 0);
        chk("R1 reset refresh", int'(store_refresh_o), 0);
        chk("R1 reset bypass", int'(bypass_o), 0);
        chk("R1 reset self refresh", int'(self_refresh_o), 0);

        // Passing check while monitoring is ignored.
        check_done_i = 1'b1;
        check_pass_i = 1'b1;
        @(negedge clk);
        check_done_i = 1'b0;
        check_pass_i = 1'b0;
        for (int i = 0; i < 6; i++) begin
            chk("R2 pass causes no program pulse", int'(prog_n_o), 1);
            chk("R2 pass keeps monitoring", int'(check_req_o), 1);
            @(negedge clk);
        end

        // Sweep program lengths and done delays; active store rotates.
        for (int pl = 0; pl <= 4; pl++) begin
            recover(pl, 3, 1 + (pl % 3), 1'b1);
            repeat (10) @(negedge clk);
            chk("R10 faulty flag sticky", int'(store_faulty_o), int'(flt_m));
            do_clear();
        end

        // Exhaust spares: two store faults, then no healthy store is left.
        recover(2, 3, 2, 1'b1);
        recover(1, 3, 1, 1'b1);
        recover(1, 3, 1, 1'b1);
        check_done_i = 1'b1;
        check_pass_i = 1'b0;
        @(negedge clk);
        check_done_i = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R9 halt ignores failed check", int'(prog_n_o), 1);
            chk("R9 halt keeps check idle", int'(check_req_o), 0);
        end
        chk("R10 bypass sticky", int'(bypass_o), 1);
        do_clear();

        // Confirmation check fails: device fault.
        recover(1, 4, 2, 1'b0);
        do_clear();

        // Timeout and last-cycle acceptance for several limits.
        for (int lim = 1; lim <= 3; lim++) begin
            recover(2, lim, 0, 1'b1);
            do_clear();
            recover(1, lim, lim, 1'b1);
            do_clear();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule